// File: doc/BRIEF.md
# Third-Order Cascaded Noise-Shaping Modulus Modulator

This block turns a static fractional word into a stream of small signed integers whose long-run mean equals that word divided by 2^ACC_W. The stream is added to the integer base of a fractional-N feedback divider, so the average division ratio lands between integers. For example, an integer base of 94 with a fraction of 0.23 gives a mean ratio of 94.23. The input word for that case is round(0.23 * 2^24) = 3858760.

Three first-order accumulator stages are chained. The residue of each stage is the addend of the next, within the same clock. The three overflow bits are merged by a difference network, so the error of the first two stages cancels. Only the third stage's error reaches the output, and it is shaped by (1 - z^-1)^3. The block is clocked from the divided feedback clock. The enable qualifies each edge, so the modulator advances once per divider output pulse.

Top module: `mash3_modulator`

## Requirements
- R1: While `rst` is high at a clock edge, all accumulators, carry delay registers and the output register clear. `code_o` reads 0 after that edge and stays 0 until the first enabled edge after reset has passed.
- R2: Each of the three stages holds an ACC_W-bit accumulator that wraps modulo 2^ACC_W. Its carry is the overflow of the add. Stage 1 adds `frac_in`. Stage 2 adds stage 1's new residue in the same cycle, and stage 3 adds stage 2's new residue.
- R3: On every enabled edge, `code_o` takes c1 + (c2 - c2') + (c3 - 2*c3' + c3''). The values c1, c2 and c3 are the carries of that edge. A prime marks the carry of the previous enabled edge, and a double prime marks the edge before that.
- R4: `code_o` is a 4-bit two's-complement value that never leaves the range -3 to +4.
- R5: An edge with `en` low changes no state, and `code_o` holds its value.
- R6: Starting from reset with a constant input x, after n enabled edges the sum S of the codes satisfies |S*2^ACC_W - n*x| <= 2*2^ACC_W.
- R7: If `frac_in` stays 0 on every enabled edge since reset, `code_o` stays 0.
- R8: A new value on `frac_in` is used from the next enabled edge onward, and the state built up before the change is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance qualifier, one step per enabled edge |
| frac_in | input | ACC_W | Fractional word, unsigned, in units of 2^-ACC_W |
| code_o | output | 4 | Signed modulus offset, registered |

## Verification
Every result is due one register after the edge that produces it. The carries of an enabled edge appear on `code_o` just after that same edge, and an edge with `en` low leaves `code_o` as it was. The bench drives inputs on the falling edge and advances its model on the rising edge. It compares one time unit later, so each comparison targets exactly the edge that was just taken. The bound on the running sum is checked at the end of each constant-input run, after n enabled edges.

// File: rtl/mash_pkg.sv
package mash_pkg;

    localparam int ORDER  = 3;
    localparam int CODE_W = 4;

    typedef logic signed [CODE_W-1:0] code_t;

    // carries of earlier enabled edges kept for the difference network
    typedef struct packed {
        logic c2_d1;
        logic c3_d1;
        logic c3_d2;
    } carry_dly_t;

    function automatic code_t bit2code(input logic b);
        return code_t'({{(CODE_W-1){1'b0}}, b});
    endfunction

    // c1 + first difference of c2 + second difference of c3
    function automatic code_t recombine(input logic [ORDER-1:0] c,
                                        input carry_dly_t d);
        code_t t;
        t = bit2code(c[0]);
        t = t + bit2code(c[1]) - bit2code(d.c2_d1);
        t = t + bit2code(c[2]) - (bit2code(d.c3_d1) <<< 1) + bit2code(d.c3_d2);
        return t;
    endfunction

endpackage

// File: rtl/mash_accum.sv
module mash_accum #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] addend_i,
    output logic         carry_o,
    output logic [W-1:0] resid_o
);
    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, addend_i};
        carry_o = sum[W];
        resid_o = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (en)
            acc_q <= resid_o;
    end
endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
    import mash_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ORDER-1:0] carry_i,
    output code_t            code_o
);
    carry_dly_t dly_q;
    code_t      code_d;

    always_comb code_d = recombine(carry_i, dly_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= '0;
            code_o <= '0;
        end else if (en) begin
            dly_q.c2_d1 <= carry_i[1];
            dly_q.c3_d1 <= carry_i[2];
            dly_q.c3_d2 <= dly_q.c3_d1;
            code_o      <= code_d;
        end
    end
endmodule

// File: rtl/mash3_modulator.sv
module mash3_modulator
    import mash_pkg::*;
#(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] frac_in,
    output logic [3:0]       code_o
);
    logic [ACC_W-1:0] addend [ORDER+1];
    logic [ORDER-1:0] carry;
    code_t            code_q;

    assign addend[0] = frac_in;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        mash_accum #(.W(ACC_W)) stage_i (
            .clk      (clk),
            .rst      (rst),
            .en       (en),
            .addend_i (addend[i]),
            .carry_o  (carry[i]),
            .resid_o  (addend[i+1])
        );
    end

    mash_recombine comb_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .carry_i (carry),
        .code_o  (code_q)
    );

    assign code_o = code_q;
endmodule

// File: rtl/mash3_modulator_chk.sv
module mash3_modulator_chk #(
    parameter int ACC_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [ACC_W-1:0] frac_in,
    input logic [3:0]       code_o
);
    logic signed [3:0] code_s;
    logic              zero_run;

    assign code_s = code_o;

    always_ff @(posedge clk) begin
        if (rst)
            zero_run <= 1'b1;
        else if (en && frac_in != '0)
            zero_run <= 1'b0;
    end

    p_reset_zero_r1: assert property (@(posedge clk) rst |=> code_o == 4'd0);

    p_code_range_r4: assert property (@(posedge clk) disable iff (rst)
        (code_s >= -4'sd3) && (code_s <= 4'sd4));

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(code_o));

    p_zero_input_r7: assert property (@(posedge clk) disable iff (rst)
        zero_run |-> code_o == 4'd0);
endmodule

bind mash3_modulator mash3_modulator_chk #(.ACC_W(ACC_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .frac_in (frac_in),
    .code_o  (code_o)
);

// File: tb/mash3_modulator_tb.sv
module mash3_modulator_tb_top;
    localparam int    W       = 24;
    localparam int    CLK_PER = 10;
    localparam longint M      = 64'd1 << W;
    localparam longint NOM    = 64'd3858760;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [W-1:0] frac_in = '0;
    logic [3:0]   code_o;

    int errors = 0;
    int checks = 0;

    longint acc[3];
    int h2, h3a, h3b, exp_code;
    longint run_sum, run_n;

    always #(CLK_PER/2) clk = ~clk;

    mash3_modulator #(.ACC_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .frac_in(frac_in), .code_o(code_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int sval();
        return int'($signed(code_o));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) acc[i] = 0;
        h2 = 0; h3a = 0; h3b = 0; exp_code = 0;
        run_sum = 0; run_n = 0;
    endtask

    // R2 behaviour: chained wrapping accumulators, carry on overflow
    task automatic model_step(input longint x);
        longint s;
        int c[3];
        longint addv;
        addv = x;
        for (int i = 0; i < 3; i++) begin
            s = acc[i] + addv;
            c[i] = (s >= M) ? 1 : 0;
            acc[i] = s % M;
            addv = acc[i];
        end
        exp_code = c[0] + (c[1] - h2) + (c[2] - 2*h3a + h3b);
        h2 = c[1]; h3b = h3a; h3a = c[2];
        run_sum += exp_code; run_n++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        repeat (2) @(posedge clk);
        model_reset();
        #1;
        check(sval() == 0, "R1", sval(), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input bit e, input longint x, input string req);
        int prev;
        @(negedge clk);
        en = e; frac_in = x[W-1:0];
        prev = sval();
        @(posedge clk);
        if (e) model_step(x);
        #1;
        check(sval() == exp_code, req, sval(), exp_code);
        if (!e) check(sval() == prev, "R5", sval(), prev);
        check(sval() >= -3 && sval() <= 4, "R4", sval(), 0);
    endtask

    task automatic check_avg(input longint x);
        longint d;
        d = run_sum * M - run_n * x;
        if (d < 0) d = -d;
        check(d <= 2*M, "R6", int'(run_sum), int'((run_n * x) / M));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R7: zero input from reset keeps the output at zero
        for (int i = 0; i < 40; i++) step(1'b1, 0, "R7");

        // nominal fraction, R3 compared every edge
        do_reset();
        for (int i = 0; i < 2000; i++) step(1'b1, NOM, "R3");
        check_avg(NOM);

        // R5: idle edges interleaved with enabled edges
        for (int i = 0; i < 300; i++) step(((i % 3) != 1), NOM, "R5");

        // R8: input change mid-run, state kept
        for (int i = 0; i < 300; i++) step(1'b1, M/2 + 12345, "R8");

        // R2: full-scale and smallest inputs, wrap behaviour
        do_reset();
        for (int i = 0; i < 500; i++) step(1'b1, M - 1, "R2");
        check_avg(M - 1);
        do_reset();
        for (int i = 0; i < 500; i++) step(1'b1, 1, "R2");
        check_avg(1);
        do_reset();
        for (int i = 0; i < 800; i++) step(1'b1, M/2, "R3");
        check_avg(M/2);

        // R1: reset in the middle of activity
        for (int i = 0; i < 50; i++) step(1'b1, 7777777, "R3");
        do_reset();
        step(1'b1, NOM, "R1");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule